// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block compares two single-cycle pulse streams, one from a divided reference and one from a divided feedback path. Each pulse latches a flag: the reference pulse sets an "up" flag and the feedback pulse sets a "down" flag. Once both flags are set, they stay set together for a fixed overlap of `OVERLAP` clock cycles. This overlap stops the detector from losing very small phase errors. Both flags then clear on the same edge. A jam-load strobe clears the flags whenever the dividers are reloaded.

The flags drive two detector outputs, and only one of them is active at a time. The single-ended detector is modelled as a pump-up drive, a pump-down drive and a high-impedance indicator. The double-ended detector is a pair of active-low outputs. Configuration inputs choose:
- the output polarity;
- which detector is active, with the other one parked in a fixed state;
- whether the lock flag is enabled.

The lock flag is high when the loop is in step and pulses low while exactly one flag is set.

Top module: `pfd_lockdet`

## Requirements
- R1: A `ref_pulse` high at a rising edge sets the up flag after that edge, and a `fb_pulse` sets the down flag in the same way. A flag that is set stays set until the overlap clear or a jam-load.
- R2: After both flags are set, they remain set together for exactly `OVERLAP` (default 2) cycles and then clear on the same edge. A pulse that arrives in the cycle of that clear sets its flag again.
- R3: A `jam_load` high at an edge clears both flags and the overlap count. Pulses in the same cycle are ignored.
- R4: With `cfg_polarity`=0 and `cfg_use_single`=1, `pump_up` follows the up flag and `pump_dn` follows the down flag. Both are driven during the overlap. `single_hiz`=1 exactly when neither pump is driven.
- R5: With `cfg_polarity`=1 and `cfg_use_single`=1, the pumps are exchanged: `pump_up` follows the down flag and `pump_dn` follows the up flag.
- R6: With `cfg_use_single`=0 and `cfg_polarity`=0, `r_out_n` is the inverse of the up flag and `v_out_n` is the inverse of the down flag. With `cfg_polarity`=1, the two outputs swap roles.
- R7: With `cfg_use_single`=1, `r_out_n` and `v_out_n` are held at 1. With `cfg_use_single`=0, both pumps are 0 and `single_hiz` is 1.
- R8: With `cfg_lock_en`=1, `lock_out` is 0 while exactly one flag is set and 1 otherwise. With `cfg_lock_en`=0, it is held at 0.
- R9: While `rst_n` is low, both flags are clear. Reset release takes effect two rising edges after `rst_n` goes high, and pulses before that are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Divided reference pulse, one cycle |
| fb_pulse | input | 1 | Divided feedback pulse, one cycle |
| jam_load | input | 1 | Divider reload strobe; clears the detector |
| cfg_polarity | input | 1 | Inverts the single-ended sense and swaps R/V |
| cfg_use_single | input | 1 | 1: single-ended detector active; 0: double-ended active |
| cfg_lock_en | input | 1 | Lock flag enable |
| pump_up | output | 1 | Single-ended source drive |
| pump_dn | output | 1 | Single-ended sink drive |
| single_hiz | output | 1 | Single-ended output is high impedance |
| r_out_n | output | 1 | Double-ended R output, active low |
| v_out_n | output | 1 | Double-ended V output, active low |
| lock_out | output | 1 | Lock flag |

## Verification
Two actions can fall in the same cycle:
- The overlap clear and a fresh pulse. The bench provokes this by placing a reference pulse exactly `OVERLAP` edges after the second flag was set. The flag must be seen set again on the next cycle, not lost.
- A jam-load and a pulse. The bench provokes this by driving both together. The flags must both read clear afterwards.

A behavioural reference model in the bench predicts every output on every cycle, across all eight configuration combinations.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic polarity;
    logic use_single;
    logic lock_en;
  } pfd_cfg_t;

  typedef struct packed {
    logic pump_up;
    logic pump_dn;
    logic hiz;
    logic r_n;
    logic v_n;
    logic lock;
  } pfd_out_t;

  // Orders the two flags according to the polarity setting.
  function automatic logic [1:0] pfd_orient(input logic pol, input logic up, input logic dn);
    return pol ? {dn, up} : {up, dn};
  endfunction

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core #(
  parameter int OVERLAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic jam,
  output logic up_q,
  output logic dn_q
);
  localparam int CW = (OVERLAP < 2) ? 1 : $clog2(OVERLAP);
  localparam logic [CW-1:0] LAST = CW'(OVERLAP - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_d, dn_d;
  logic          both, last, flag_en, cnt_en;

  assign both    = up_q & dn_q;
  assign last    = both & (cnt_q == LAST);
  assign flag_en = jam | ref_pulse | fb_pulse | last;
  assign cnt_en  = jam | both;

  always_comb begin
    up_d  = up_q;
    dn_d  = dn_q;
    cnt_d = cnt_q;
    if (jam) begin
      up_d  = 1'b0;
      dn_d  = 1'b0;
      cnt_d = '0;
    end else if (last) begin
      up_d  = ref_pulse;
      dn_d  = fb_pulse;
      cnt_d = '0;
    end else begin
      up_d  = up_q | ref_pulse;
      dn_d  = dn_q | fb_pulse;
      if (both) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (flag_en) begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_JAM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    jam |=> (!up_q && !dn_q)); // R3
  AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !dn_q && !jam) |=> up_q); // R1
  AST_DN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_q && !up_q && !jam) |=> dn_q); // R1
  AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |-> (cnt_q <= LAST)); // R2
endmodule

// File: rtl/pfd_out_steer.sv
module pfd_out_steer
  import pfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     up,
  input  logic     dn,
  input  pfd_cfg_t cfg,
  output pfd_out_t outs
);
  logic [1:0] ori;

  assign ori = pfd_orient(cfg.polarity, up, dn);

  always_comb begin
    outs.pump_up = cfg.use_single & ori[1];
    outs.pump_dn = cfg.use_single & ori[0];
    outs.hiz     = ~(outs.pump_up | outs.pump_dn);
    outs.r_n     = cfg.use_single | ~ori[1];
    outs.v_n     = cfg.use_single | ~ori[0];
    outs.lock    = cfg.lock_en & ~(up ^ dn);
  end

  AST_DOUBLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.use_single |-> (outs.r_n && outs.v_n)); // R7
  AST_SINGLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.use_single |-> (outs.hiz && !outs.pump_up && !outs.pump_dn)); // R7
  AST_LOCK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.lock_en |-> !outs.lock); // R8
  AST_BOTH_DRIVE_ONLY_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (outs.pump_up && outs.pump_dn) |-> (up && dn)); // R4
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet
  import pfd_pkg::*;
#(
  parameter int OVERLAP    = 2,
  parameter int SYNC_STAGE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic jam_load,
  input  logic cfg_polarity,
  input  logic cfg_use_single,
  input  logic cfg_lock_en,
  output logic pump_up,
  output logic pump_dn,
  output logic single_hiz,
  output logic r_out_n,
  output logic v_out_n,
  output logic lock_out
);
  logic     rst_n_core;
  logic     up_flag, dn_flag;
  pfd_cfg_t cfg;
  pfd_out_t outs;

  assign cfg = '{polarity: cfg_polarity, use_single: cfg_use_single, lock_en: cfg_lock_en};

  pfd_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_core)
  );

  pfd_flag_core #(.OVERLAP(OVERLAP)) u_core (
    .clk(clk), .rst_n(rst_n_core), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .jam(jam_load), .up_q(up_flag), .dn_q(dn_flag)
  );

  pfd_out_steer u_steer (
    .clk(clk), .rst_n(rst_n_core), .up(up_flag), .dn(dn_flag), .cfg(cfg), .outs(outs)
  );

  assign pump_up    = outs.pump_up;
  assign pump_dn    = outs.pump_dn;
  assign single_hiz = outs.hiz;
  assign r_out_n    = outs.r_n;
  assign v_out_n    = outs.v_n;
  assign lock_out   = outs.lock;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n_core |-> (!up_flag && !dn_flag)); // R9
endmodule

// File: tb/pfd_lockdet_bench.sv
module pfd_lockdet_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0, fb_pulse = 1'b0, jam_load = 1'b0;
  logic cfg_polarity = 1'b0, cfg_use_single = 1'b1, cfg_lock_en = 1'b1;
  logic pump_up, pump_dn, single_hiz, r_out_n, v_out_n, lock_out;

  int checks = 0;
  int fails = 0;
  string cur_req = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lockdet #(.OVERLAP(OV)) u_pfd_lockdet (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .jam_load(jam_load), .cfg_polarity(cfg_polarity), .cfg_use_single(cfg_use_single),
    .cfg_lock_en(cfg_lock_en), .pump_up(pump_up), .pump_dn(pump_dn),
    .single_hiz(single_hiz), .r_out_n(r_out_n), .v_out_n(v_out_n), .lock_out(lock_out)
  );

  // Behavioural reference model
  int m_up = 0, m_dn = 0, m_cnt = 0, m_sync = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_up = 0; m_dn = 0; m_cnt = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else if (jam_load) begin
      m_up = 0; m_dn = 0; m_cnt = 0;
    end else if (m_up == 1 && m_dn == 1) begin
      if (m_cnt == OV - 1) begin
        m_up = int'(ref_pulse); m_dn = int'(fb_pulse); m_cnt = 0;
      end else m_cnt = m_cnt + 1;
    end else begin
      if (ref_pulse) m_up = 1;
      if (fb_pulse)  m_dn = 1;
    end
  end

  task automatic check1(input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    begin
      logic eu, ed, src, snk;
      eu  = (m_up == 1);
      ed  = (m_dn == 1);
      src = cfg_polarity ? ed : eu;
      snk = cfg_polarity ? eu : ed;
      check1("pump_up",    pump_up,    cfg_use_single && src);
      check1("pump_dn",    pump_dn,    cfg_use_single && snk);
      check1("single_hiz", single_hiz, !(cfg_use_single && (src || snk)));
      check1("r_out_n",    r_out_n,    cfg_use_single || !src);
      check1("v_out_n",    v_out_n,    cfg_use_single || !snk);
      check1("lock_out",   lock_out,   cfg_lock_en && (eu == ed));
    end
  end

  task automatic step(input logic r, input logic f, input logic j);
    @(negedge clk);
    ref_pulse = r; fb_pulse = f; jam_load = j;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic patterns();
    step(1, 0, 0); idle(2); step(0, 1, 0); idle(4);   // reference leads
    step(0, 1, 0); idle(3); step(1, 0, 0); idle(4);   // feedback leads
    step(1, 1, 0); idle(4);                           // in step
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cur_req = "R9";
    idle(3);
    rst_n = 1'b1;
    step(1, 1, 0);                  // ignored: sync not yet released
    idle(4);

    cur_req = "R1";
    step(1, 0, 0); idle(5);
    step(0, 1, 0); idle(4);
    step(0, 1, 0); idle(3); step(1, 0, 0); idle(4);

    cur_req = "R2";
    step(1, 0, 0); idle(1); step(0, 1, 0); idle(1);
    step(1, 0, 0);                  // lands in the clearing cycle
    idle(3); step(0, 1, 0); idle(4);
    step(1, 1, 0); step(1, 1, 0); step(1, 1, 0); idle(4);

    cur_req = "R3";
    step(1, 0, 0); idle(2); step(0, 1, 1); idle(3);
    step(1, 0, 1); idle(3);
    step(1, 1, 0); step(0, 0, 1); idle(3);

    cfg_use_single = 1'b1; cfg_lock_en = 1'b1;
    cur_req = "R4"; cfg_polarity = 1'b0; patterns();
    cur_req = "R5"; cfg_polarity = 1'b1; patterns();
    cfg_use_single = 1'b0;
    cur_req = "R6"; cfg_polarity = 1'b0; patterns();
    cfg_polarity = 1'b1; patterns();

    cur_req = "R7";
    for (int c = 0; c < 4; c++) begin
      step(1, 0, 0);
      cfg_use_single = c[0]; cfg_polarity = c[1];
      idle(2);
      cfg_use_single = ~c[0];
      idle(1); step(0, 1, 0); idle(4);
    end

    cur_req = "R8";
    for (int c = 0; c < 8; c++) begin
      cfg_polarity = c[0]; cfg_use_single = c[1]; cfg_lock_en = c[2];
      patterns();
    end

    cur_req = "R9";
    step(1, 0, 0); idle(1);
    rst_n = 1'b0; idle(3);
    rst_n = 1'b1; idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule